// File: doc/BRIEF.md
# Key-Protected Clock Control Register Unit

This unit holds two small control registers for a clock system: a clock-mode register that selects how the clock system operates, and a power register that sets the core-clock divide ratio and requests power-down. Software reaches both through a plain single-cycle write bus. Neither register takes a write unless it comes inside a fixed three-write unlock sequence. The sequence is: a first key value, then the data aimed at the register, then a closing key value. Each register has its own keys. Both registers can be read back on dedicated outputs at any time, with no key needed.

The power register's divider field drives a clock-enable generator that runs on the fast incoming clock. It asserts a one-cycle enable once every 2^CD fast cycles, so the core can run at binary submultiples of the fast clock. Logic downstream gates its registers with this enable. The unit does not make a derived clock. A new divide setting is taken up only at an enable pulse, so every enable interval has either the old length or the new one. The power-down bit is passed out as a plain request flag.

The write bus has no back-pressure. Each cycle with `wr_en` high is one write, and the unit accepts every such write. There is no ready signal, and no data stream leaves the unit.

Top module: `clkctl_keyed`

## Requirements
- R1: After reset, `mode_q` is 0x00, `pwr_q` is 0x03, `cur_div` is 3 and `pdown_req` is 0.
- R2: The clock-mode register is written by three consecutive bus writes: 0xAA to address 0, then the data to address 1, then 0x55 to address 2. The data appears on `mode_q` in the cycle after the third write.
- R3: The power register is written by three consecutive bus writes: 0x01 to address 3, then the data to address 4, then 0xF4 to address 3. The data appears on `pwr_q` in the cycle after the third write.
- R4: A write that is not the next expected step of a sequence returns that register's unlock tracker to idle and discards any staged data. Such writes include a wrong key value, a wrong address, and a write belonging to the other register. The register then keeps its value, even if a correct closing key follows.
- R5: A write to a register's data address (1 or 4) with no preceding key write has no effect on `mode_q` or `pwr_q`.
- R6: `core_en` is high for one fast cycle in every 2^`cur_div` fast cycles. After reset is released, the first pulse comes on the 7th rising edge, and pulses then repeat every 8 cycles.
- R7: The divider field is `pwr_q[2:0]`. A stored value of 7 is reserved: `pwr_q` still reads 7, but `cur_div` is clamped to 6 and `core_en` repeats every 64 cycles.
- R8: `cur_div` changes only in the cycle after a `core_en` pulse. The interval in which a new divider is written keeps the old length, and the intervals after it take the new length.
- R9: `pdown_req` follows bit 3 of the power register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe; one write per cycle when high |
| wr_addr | input | ADDR_W (4) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| mode_q | output | DATA_W (8) | Clock-mode register readback |
| pwr_q | output | DATA_W (8) | Power register readback |
| core_en | output | 1 | Core clock-enable pulse |
| cur_div | output | CD_W (3) | Divider exponent currently in use |
| pdown_req | output | 1 | Power-down request |

## Verification
The properties assume that `wr_addr` and `wr_data` are meaningful only while `wr_en` is high, and that each write lasts exactly one cycle. They also assume that only a closing-key write can change a register. The stimulus drives the bus on falling edges and holds `wr_en` high for a single rising edge per write. It returns the strobe low between tasks, so every write is seen exactly once. In the divider-change test, the bus writes happen only in the middle of an enable interval, so the measured interval lengths depend only on the rule that changes take effect at pulse boundaries.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  // Address map
  localparam int MODE_KEYA_ADDR = 0;
  localparam int MODE_DATA_ADDR = 1;
  localparam int MODE_KEYB_ADDR = 2;
  localparam int PWR_KEY_ADDR   = 3;
  localparam int PWR_DATA_ADDR  = 4;

  // Key values
  localparam int MODE_KEY1 = 'hAA;
  localparam int MODE_KEY2 = 'h55;
  localparam int PWR_KEY1  = 'h01;
  localparam int PWR_KEY2  = 'hF4;

  // Reset contents
  localparam int MODE_RST = 'h00;
  localparam int PWR_RST  = 'h03;

  // Power register field positions
  localparam int PD_BIT = 3;

  typedef enum logic [1:0] {
    UNL_IDLE   = 2'd0,
    UNL_ARMED  = 2'd1,
    UNL_STAGED = 2'd2
  } unlock_t;

endpackage

// File: rtl/clkctl_keyed_reg.sv
module clkctl_keyed_reg
  import clkctl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int K1_ADDR = 0,
  parameter int K1_VAL  = 0,
  parameter int D_ADDR  = 1,
  parameter int K2_ADDR = 2,
  parameter int K2_VAL  = 0,
  parameter int RST_VAL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);

  unlock_t           st;
  logic [DATA_W-1:0] staged;
  logic              hit_k1, hit_data, hit_k2;

  always_comb begin
    hit_k1   = (wr_addr == ADDR_W'(K1_ADDR)) && (wr_data == DATA_W'(K1_VAL));
    hit_data = (wr_addr == ADDR_W'(D_ADDR));
    hit_k2   = (wr_addr == ADDR_W'(K2_ADDR)) && (wr_data == DATA_W'(K2_VAL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= UNL_IDLE;
      staged <= '0;
      q      <= DATA_W'(RST_VAL);
    end else if (wr_en) begin
      case (st)
        UNL_IDLE: begin
          if (hit_k1) st <= UNL_ARMED;
        end
        UNL_ARMED: begin
          if (hit_data) begin
            st     <= UNL_STAGED;
            staged <= wr_data;
          end else begin
            st <= UNL_IDLE;
          end
        end
        UNL_STAGED: begin
          if (hit_k2) q <= staged;
          st     <= UNL_IDLE;
          staged <= '0;
        end
        default: begin
          st     <= UNL_IDLE;
          staged <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/clkctl_en_div.sv
module clkctl_en_div #(
  parameter int CD_W   = 3,
  parameter int CD_MAX = 6,
  parameter int CD_RST = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CD_W-1:0] cd_raw,
  output logic            en,
  output logic [CD_W-1:0] cd_act
);

  localparam int CNT_W = (CD_MAX < 1) ? 1 : CD_MAX;

  logic [CD_W-1:0]  cd_req;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // Reserved codes above CD_MAX fall back to the slowest legal ratio
  always_comb begin
    cd_req = (cd_raw > CD_W'(CD_MAX)) ? CD_W'(CD_MAX) : cd_raw;
    lim    = (CNT_W'(1) << cd_act) - CNT_W'(1);
    en     = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cd_act <= CD_W'(CD_RST);
    end else if (en) begin
      cnt    <= '0;
      cd_act <= cd_req;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/clkctl_keyed.sv
module clkctl_keyed
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CD_W   = 3,
  parameter int CD_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] pwr_q,
  output logic              core_en,
  output logic [CD_W-1:0]   cur_div,
  output logic              pdown_req
);

  clkctl_keyed_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .K1_ADDR(MODE_KEYA_ADDR), .K1_VAL(MODE_KEY1),
    .D_ADDR(MODE_DATA_ADDR),
    .K2_ADDR(MODE_KEYB_ADDR), .K2_VAL(MODE_KEY2),
    .RST_VAL(MODE_RST)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .q(mode_q)
  );

  clkctl_keyed_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .K1_ADDR(PWR_KEY_ADDR), .K1_VAL(PWR_KEY1),
    .D_ADDR(PWR_DATA_ADDR),
    .K2_ADDR(PWR_KEY_ADDR), .K2_VAL(PWR_KEY2),
    .RST_VAL(PWR_RST)
  ) u_pwr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .q(pwr_q)
  );

  clkctl_en_div #(
    .CD_W(CD_W), .CD_MAX(CD_MAX), .CD_RST(PWR_RST)
  ) u_div (
    .clk(clk), .rst_n(rst_n),
    .cd_raw(pwr_q[CD_W-1:0]),
    .en(core_en), .cd_act(cur_div)
  );

  assign pdown_req = pwr_q[PD_BIT];

endmodule

// File: rtl/clkctl_keyed_chk.sv
module clkctl_keyed_chk
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CD_W   = 3,
  parameter int CD_MAX = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] pwr_q,
  input logic              core_en,
  input logic [CD_W-1:0]   cur_div
);

  logic [7:0] gap;
  logic       mode_close, pwr_close;

  always_comb begin
    mode_close = wr_en && (wr_addr == ADDR_W'(MODE_KEYB_ADDR)) && (wr_data == DATA_W'(MODE_KEY2));
    pwr_close  = wr_en && (wr_addr == ADDR_W'(PWR_KEY_ADDR))   && (wr_data == DATA_W'(PWR_KEY2));
  end

  // Cycles without a pulse since the last pulse (or since reset)
  always_ff @(posedge clk) begin
    if (!rst_n)       gap <= '0;
    else if (core_en) gap <= '0;
    else              gap <= gap + 8'd1;
  end

  assert_mode_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_close |=> $stable(mode_q));

  assert_pwr_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_close |=> $stable(pwr_q));

  assert_pulse_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (32'(gap) == (32'd1 << cur_div) - 32'd1));

  assert_div_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(cur_div));

  always @(negedge clk) begin
    if (rst_n) begin
      assert_div_clamped_R7: assert (32'(cur_div) <= CD_MAX);
    end
  end

endmodule

bind clkctl_keyed clkctl_keyed_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CD_W(CD_W), .CD_MAX(CD_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode_q(mode_q), .pwr_q(pwr_q),
  .core_en(core_en), .cur_div(cur_div)
);

// File: tb/clkctl_keyed_bench.sv
module clkctl_keyed_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] mode_q, pwr_q;
  logic       core_en, pdown_req;
  logic [2:0] cur_div;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  clkctl_keyed u_clkctl_keyed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .pwr_q(pwr_q),
    .core_en(core_en), .cur_div(cur_div), .pdown_req(pdown_req)
  );

  // {addr, data, expected mode_q, expected pwr_q}
  localparam int NV = 26;
  localparam logic [31:0] VEC [NV] = '{
    32'h01_5A_00_03,                                   // R5 data without keys
    32'h00_AA_00_03, 32'h01_21_00_03, 32'h02_55_21_03, // R2 mode commit
    32'h03_01_21_03, 32'h04_0A_21_03, 32'h03_F4_21_0A, // R3 power commit
    32'h00_AA_21_0A, 32'h01_77_21_0A, 32'h02_54_21_0A, // R4 wrong closing key
    32'h00_AA_21_0A, 32'h03_01_21_0A,                  // R4 other register breaks
    32'h01_33_21_0A, 32'h02_55_21_0A,
    32'h03_01_21_0A, 32'h04_05_21_0A,                  // R4 mode key breaks power
    32'h00_AA_21_0A, 32'h03_F4_21_0A,
    32'h00_AA_21_0A, 32'h00_AA_21_0A,                  // R4 repeated key breaks
    32'h01_44_21_0A, 32'h02_55_21_0A,
    32'h03_01_21_0A, 32'h04_01_21_0A, 32'h03_F4_21_01, // R3 second commit
    32'h01_99_21_01                                    // R5 again
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_pwr(input logic [7:0] d);
    wr(4'd3, 8'h01); wr(4'd4, d); wr(4'd3, 8'hF4);
  endtask

  // Length in cycles of the next complete enable interval
  task automatic period(output int p);
    while (!core_en) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!core_en);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int p;
    int n;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      chk($sformatf("R2/R4/R5 mode vec%0d", i), mode_q, VEC[i][15:8]);
      chk($sformatf("R3/R4/R5 pwr vec%0d", i), pwr_q, VEC[i][7:0]);
      chk($sformatf("R9 pdown vec%0d", i), pdown_req, VEC[i][3]);
    end

    // R1 reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mode", mode_q, 8'h00);
    chk("R1 pwr", pwr_q, 8'h03);
    chk("R1 div", cur_div, 3);
    chk("R1 pdown", pdown_req, 0);
    rst_n = 1'b1;

    // R6 first pulse after seven edges, then every 8
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_en && n < 100);
    chk("R6 first pulse", n, 7);
    period(p);
    chk("R6 period cd3", p, 8);

    // R6 divide by one
    wr_pwr(8'h00);
    period(p);
    period(p);
    chk("R6 period cd0", p, 1);
    chk("R6 div cd0", cur_div, 0);

    // R7 reserved code clamps
    wr_pwr(8'h07);
    chk("R7 readback", pwr_q, 8'h07);
    period(p);
    period(p);
    chk("R7 div clamp", cur_div, 6);
    chk("R7 period", p, 64);

    // R8 change mid-interval keeps old length
    while (!core_en) @(negedge clk);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      n++;
    end
    wr_pwr(8'h09);
    n += 3;
    chk("R8 div held", cur_div, 6);
    chk("R9 pdown set", pdown_req, 1);
    while (!core_en) begin
      @(negedge clk);
      n++;
    end
    chk("R8 old interval", n, 64);
    @(negedge clk);
    chk("R8 div updated", cur_div, 1);
    period(p);
    chk("R8 new interval", p, 2);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule